// File: doc/BRIEF.md
# Linear Chain Spare-Bypass Reconfigurator

This block sets up a linear chain of processing elements that has spare elements built in. The chain has `N_LOG + N_SPARE` physical elements in a row. Data enters at physical element 0 and leaves after the highest-numbered element. The caller gives a defect mask with one bit for each physical element and pulses a reconfigure strobe. The block then works out a bypass setting for every element. Defective elements are skipped. The first `N_LOG` healthy elements, counted from the input end, become the working chain. Healthy elements beyond those are skipped and left idle.

The block also outputs a table that maps each logical position to a physical element. It raises a failure flag when too few healthy elements exist to fill every logical position. The processing elements are stubs. Each active one applies a transform that depends on its physical index, so the chain output shows which elements data passed through and in what order.

The configuration is held in registers. It changes only when the strobe is pulsed. With the default sizes, any 8 defects among 72 elements leave a working 64-element chain.

Top module: `lin_spare_reconfig`

## Requirements
- R1: While `rst` is high, every `bypass` bit is 1, `config_fail` is 0, `log2phys` is all zeros and `data_out` is 0.
- R2: After a strobe, every element whose `defect_mask` bit was 1 when the strobe was sampled has its `bypass` bit set to 1.
- R3: When enough healthy elements exist, the `N_LOG` healthy elements with the lowest indices have `bypass` 0. Every other element has `bypass` 1, so exactly `N_LOG` elements are active.
- R4: Field k of `log2phys` (bits `[k*PW +: PW]`, with k counted from 0) holds the physical index of the k-th healthy element counted from index 0. Fields therefore rise strictly with k.
- R5: An active element i turns its input d into `{d[W-2:0], d[W-1]} ^ (i+1)`. A bypassed element passes d through unchanged. Data goes through the elements in ascending index order. `data_out` is the chain result for `data_in`, registered with one cycle of latency.
- R6: If fewer than `N_LOG` elements are healthy, `config_fail` is 1, all `bypass` bits are 1 and `log2phys` is all zeros, so `data_out` equals the previous cycle's `data_in`.
- R7: The configuration outputs take their new value on the clock edge that samples `reconfig` high. Between strobes they do not change, whatever `defect_mask` does.
- R8: Exactly `N_SPARE` defects in any positions (all at the input end, all at the output end, or scattered) give `config_fail` 0 and a full chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reconfig | input | 1 | Strobe: load a configuration from `defect_mask` |
| defect_mask | input | P | 1 marks a defective physical element |
| data_in | input | DW | Data entering the chain at element 0 |
| data_out | output | DW | Registered data leaving the chain |
| bypass | output | P | 1 means the element is skipped |
| log2phys | output | N_LOG*PW | Physical index for each logical position |
| config_fail | output | 1 | Too few healthy elements |

## Verification
The hardest case to reach is exactly at the edge of capacity. Here the healthy count equals `N_LOG`, so every healthy element must be used and the last logical position lands on the highest index. One healthy element fewer must flip the block into failure.

The stimulus table places exactly `N_SPARE` defects in three ways: grouped at the input end, grouped at the output end, and scattered. It places one more defect next to a grouped set. The table also includes a mask in which every element is defective.

A separate directed step changes the mask without pulsing the strobe. It then checks that neither the configuration nor the data path moves.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

    parameter int unsigned DEF_N = 64;
    parameter int unsigned DEF_S = 8;
    parameter int unsigned DEF_W = 16;

    typedef enum logic {
        PE_ACTIVE = 1'b0,
        PE_SKIP   = 1'b1
    } pe_mode_e;

    function automatic pe_mode_e mode_of(input logic byp);
        return byp ? PE_SKIP : PE_ACTIVE;
    endfunction

endpackage

// File: rtl/lcr_mapper.sv
module lcr_mapper #(
    parameter int N_LOG   = 64,
    parameter int N_SPARE = 8,
    localparam int P      = N_LOG + N_SPARE,
    localparam int PW     = $clog2(P)
) (
    input  logic [P-1:0]        defect_mask,
    output logic [P-1:0]        bypass_nxt,
    output logic [N_LOG*PW-1:0] map_nxt,
    output logic                fail_nxt
);

    int unsigned rank;

    always_comb begin
        rank       = 0;
        bypass_nxt = '1;
        map_nxt    = '0;
        for (int i = 0; i < P; i++) begin
            if (!defect_mask[i]) begin
                if (rank < N_LOG) begin
                    bypass_nxt[i]             = 1'b0;
                    map_nxt[rank*PW +: PW]    = PW'(i);
                end
                rank = rank + 1;
            end
        end
        fail_nxt = (rank < N_LOG);
        if (fail_nxt) begin
            bypass_nxt = '1;
            map_nxt    = '0;
        end
    end

endmodule

// File: rtl/lcr_cfg_store.sv
module lcr_cfg_store #(
    parameter int N_LOG   = 64,
    parameter int N_SPARE = 8,
    localparam int P      = N_LOG + N_SPARE,
    localparam int PW     = $clog2(P)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [P-1:0]        bypass_nxt,
    input  logic [N_LOG*PW-1:0] map_nxt,
    input  logic                fail_nxt,
    output logic [P-1:0]        bypass_q,
    output logic [N_LOG*PW-1:0] map_q,
    output logic                fail_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bypass_q <= '1;
            map_q    <= '0;
            fail_q   <= 1'b0;
        end else if (load) begin
            bypass_q <= bypass_nxt;
            map_q    <= map_nxt;
            fail_q   <= fail_nxt;
        end
    end

endmodule

// File: rtl/lcr_pe_stub.sv
module lcr_pe_stub
    import lcr_pkg::*;
#(
    parameter int DW = 16,
    parameter int ID = 0
) (
    input  pe_mode_e        mode,
    input  logic [DW-1:0]   d_i,
    output logic [DW-1:0]   d_o
);

    logic [DW-1:0] worked;

    assign worked = {d_i[DW-2:0], d_i[DW-1]} ^ DW'(ID + 1);

    always_comb begin
        unique case (mode)
            PE_ACTIVE: d_o = worked;
            PE_SKIP:   d_o = d_i;
            default:   d_o = d_i;
        endcase
    end

endmodule

// File: rtl/lin_spare_reconfig.sv
module lin_spare_reconfig
    import lcr_pkg::*;
#(
    parameter int N_LOG   = DEF_N,
    parameter int N_SPARE = DEF_S,
    parameter int DW      = DEF_W,
    localparam int P      = N_LOG + N_SPARE,
    localparam int PW     = $clog2(P)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reconfig,
    input  logic [P-1:0]        defect_mask,
    input  logic [DW-1:0]       data_in,
    output logic [DW-1:0]       data_out,
    output logic [P-1:0]        bypass,
    output logic [N_LOG*PW-1:0] log2phys,
    output logic                config_fail
);

    logic [P-1:0]        byp_calc;
    logic [N_LOG*PW-1:0] map_calc;
    logic                fail_calc;

    lcr_mapper #(.N_LOG(N_LOG), .N_SPARE(N_SPARE)) u_mapper (
        .defect_mask (defect_mask),
        .bypass_nxt  (byp_calc),
        .map_nxt     (map_calc),
        .fail_nxt    (fail_calc)
    );

    lcr_cfg_store #(.N_LOG(N_LOG), .N_SPARE(N_SPARE)) u_store (
        .clk        (clk),
        .rst        (rst),
        .load       (reconfig),
        .bypass_nxt (byp_calc),
        .map_nxt    (map_calc),
        .fail_nxt   (fail_calc),
        .bypass_q   (bypass),
        .map_q      (log2phys),
        .fail_q     (config_fail)
    );

    logic [DW-1:0] link [P+1];

    assign link[0] = data_in;

    for (genvar g = 0; g < P; g++) begin : g_pe
        lcr_pe_stub #(.DW(DW), .ID(g)) u_pe (
            .mode (mode_of(bypass[g])),
            .d_i  (link[g]),
            .d_o  (link[g+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) data_out <= '0;
        else     data_out <= link[P];
    end

endmodule

// File: rtl/lcr_checker.sv
module lcr_checker #(
    parameter int N_LOG   = 64,
    parameter int N_SPARE = 8,
    localparam int P      = N_LOG + N_SPARE,
    localparam int PW     = $clog2(P)
) (
    input logic                clk,
    input logic                rst,
    input logic                reconfig,
    input logic [P-1:0]        defect_mask,
    input logic [P-1:0]        bypass,
    input logic [N_LOG*PW-1:0] log2phys,
    input logic                config_fail
);

    p_defect_skipped_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(reconfig) && !$past(rst)) |->
            ((bypass & $past(defect_mask)) == $past(defect_mask)));

    p_active_count_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(reconfig) && !$past(rst) && !config_fail) |->
            ($countones(~bypass) == N_LOG));

    p_fail_all_skip_r6: assert property (@(posedge clk) disable iff (rst)
        config_fail |-> (&bypass));

    p_hold_between_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(reconfig) |-> ($stable(bypass) && $stable(config_fail) && $stable(log2phys)));

    for (genvar k = 1; k < N_LOG; k++) begin : g_ord
        p_map_rising_r4: assert property (@(posedge clk) disable iff (rst)
            ($past(reconfig) && !$past(rst) && !config_fail) |->
                (log2phys[k*PW +: PW] > log2phys[(k-1)*PW +: PW]));
    end

endmodule

bind lin_spare_reconfig lcr_checker #(.N_LOG(N_LOG), .N_SPARE(N_SPARE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reconfig    (reconfig),
    .defect_mask (defect_mask),
    .bypass      (bypass),
    .log2phys    (log2phys),
    .config_fail (config_fail)
);

// File: tb/tb_lin_spare_reconfig.sv
module tb_lin_spare_reconfig;

    localparam int N  = 64;
    localparam int S  = 8;
    localparam int P  = N + S;
    localparam int PW = $clog2(P);
    localparam int W  = 16;
    localparam int NV = 8;

    // each entry: {defect mask, data word}
    localparam logic [P+W-1:0] VEC [NV] = '{
        {72'h00_0000_0000_0000_0000, 16'h1234},  // R3 no defects
        {72'h00_0000_0000_0000_00FF, 16'hBEEF},  // R8 spares at input end
        {72'hFF_0000_0000_0000_0000, 16'h0001},  // R8 spares at output end
        {72'h80_0000_0001_0000_8421, 16'hA5A5},  // R2 scattered
        {72'h01_0000_0000_0000_0000, 16'hFFFF},  // R3 single defect
        {72'h00_0000_0000_0000_01FF, 16'h0F0F},  // R6 one over capacity
        {72'hFF_FFFF_FFFF_FFFF_FFFF, 16'h5555},  // R6 all defective
        {72'h80_8000_0000_8003_0421, 16'h7E81}   // R8 eight scattered
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                reconfig = 1'b0;
    logic [P-1:0]        defect_mask = '0;
    logic [W-1:0]        data_in = '0;
    logic [W-1:0]        data_out;
    logic [P-1:0]        bypass;
    logic [N*PW-1:0]     log2phys;
    logic                config_fail;

    int n_chk = 0;
    int n_bad = 0;

    lin_spare_reconfig dut (
        .clk(clk), .rst(rst), .reconfig(reconfig), .defect_mask(defect_mask),
        .data_in(data_in), .data_out(data_out), .bypass(bypass),
        .log2phys(log2phys), .config_fail(config_fail)
    );

    always #10 clk = ~clk;

    logic [P-1:0]    e_byp;
    logic [N*PW-1:0] e_map;
    logic            e_fail;

    task automatic model(input logic [P-1:0] m);
        int got;
        got    = 0;
        e_byp  = '1;
        e_map  = '0;
        for (int i = 0; i < P; i++) begin
            if (m[i] == 1'b0) begin
                if (got < N) begin
                    e_byp[i] = 1'b0;
                    e_map[got*PW +: PW] = PW'(i);
                end
                got++;
            end
        end
        e_fail = (got < N);
        if (e_fail) begin
            e_byp = '1;
            e_map = '0;
        end
    endtask

    function automatic logic [W-1:0] chain(input logic [P-1:0] byp, input logic [W-1:0] d);
        logic [W-1:0] x;
        x = d;
        for (int i = 0; i < P; i++)
            if (!byp[i]) x = {x[W-2:0], x[W-1]} ^ W'(i + 1);
        return x;
    endfunction

    task automatic chk(input string tag, input logic [N*PW-1:0] act, input logic [N*PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [P-1:0] m);
        @(negedge clk);
        defect_mask = m;
        reconfig    = 1'b1;
        @(negedge clk);
        reconfig    = 1'b0;
    endtask

    task automatic push(input logic [W-1:0] d);
        data_in = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, sampled while reset is held
        chk("R1 bypass", (N*PW)'(bypass), (N*PW)'({P{1'b1}}));
        chk("R1 config_fail", (N*PW)'(config_fail), '0);
        chk("R1 log2phys", log2phys, '0);
        chk("R1 data_out", (N*PW)'(data_out), '0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [P-1:0] m;
            logic [W-1:0] d;
            m = VEC[v][P+W-1:W];
            d = VEC[v][W-1:0];
            model(m);
            strobe(m);
            chk("R2/R3/R8 bypass", (N*PW)'(bypass), (N*PW)'(e_byp));
            chk("R6/R8 config_fail", (N*PW)'(config_fail), (N*PW)'(e_fail));
            chk("R4 log2phys", log2phys, e_map);
            push(d);
            chk("R5 data_out", (N*PW)'(data_out), (N*PW)'(chain(e_byp, d)));
        end

        // R7: mask changes without a strobe have no effect
        model(72'h00_0000_0000_0000_0F00);
        strobe(72'h00_0000_0000_0000_0F00);
        defect_mask = 72'hFF_FFFF_FFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        chk("R7 bypass held", (N*PW)'(bypass), (N*PW)'(e_byp));
        chk("R7 fail held", (N*PW)'(config_fail), (N*PW)'(e_fail));
        chk("R7 map held", log2phys, e_map);
        push(16'hC3C3);
        chk("R7 data path held", (N*PW)'(data_out), (N*PW)'(chain(e_byp, 16'hC3C3)));

        // R6: failed config gives straight-through data with one cycle delay
        strobe(72'h00_0000_0000_0000_03FF);
        push(16'h2468);
        chk("R6 passthrough", (N*PW)'(data_out), (N*PW)'(16'h2468));

        // R4: last logical slot lands on the top element when spares sit at the input end
        strobe(72'h00_0000_0000_0000_00FF);
        chk("R4 last slot", (N*PW)'(log2phys[(N-1)*PW +: PW]), (N*PW)'(P - 1));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20ns * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule